// File: doc/BRIEF.md
# Dual-Counter Timer with PWM Output

This peripheral holds two counters, channel 0 and channel 1, each with a control/status register, a load register and a read-only count register on a simple 32-bit register bus. A counter counts either up or down. It can copy its load value into its count under software control. At the end of every period it reloads by itself or stops. Each period end makes a one-cycle pulse on the channel's generate output.

When both channels are set up for pulse-width operation, the two counters together drive one PWM pin. Channel 0 sets the period. Channel 1 sets the high time and is restarted at every period boundary, so the two counters never drift apart. A single control write can start both counters in the same cycle. New load values take effect only when a counter reloads, so the waveform never changes in the middle of a period.

Top module: `dual_timer_pwm`

## Requirements
- R1: Register map, with byte addresses decoded only when the low two address bits are zero:
  - channel 0: control at 0x00, load at 0x04, count at 0x08;
  - channel 1: control at 0x10, load at 0x14, count at 0x18;
  - count registers are read-only and ignore writes;
  - unmapped addresses, control bits 10 and above 11, and load bits at or above the counter width read as zero;
  - every register reads zero after reset.
- R2: The control bit positions are: 0 capture-mode select (must be 0 for generate and PWM), 1 count down, 2 generate-output enable, 3 capture enable (stored only), 4 auto-reload, 5 load, 6 interrupt enable (stored only), 7 run, 8 period flag, 9 PWM enable, 10 start-both strobe, 11 chaining (stored only, blocks PWM).
- R3: While the load bit is set, the counter copies its load register into its count register on every clock and does not count.
- R4: When counting down from load value L with auto-reload, the counter repeats every L+2 cycles. When bit 2 is set and bit 0 is clear, the generate output gives a one-cycle pulse once per period.
- R5: When counting up from load value L, the period is MAX-L+2 cycles, where MAX is the all-ones value of the WIDTH-bit counter.
- R6: Without auto-reload, the counter stops after one period. Hardware clears its run bit and sets the period flag (bit 8). Writing 1 to bit 8 clears the flag.
- R7: Writing bit 10 to either control register sets the run bit of both channels at the same clock edge. Bit 10 itself reads as 0.
- R8: The PWM output is active only when both control registers have capture-mode 0, PWM enable 1, generate enable 1, run 1, auto-reload 1, load 0 and chaining 0.
- R9: While active, the PWM output is high from the start of each period for the channel 1 cycle count, then low until the channel 0 period ends. The period is the channel 0 cycle count.
- R10: If the channel 1 cycle count is greater than or equal to the channel 0 cycle count, the PWM output stays low.
- R11: While PWM operation is inactive, the PWM output is low.
- R12: A load value written while PWM is running changes neither the current period nor the current high time. It applies from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| genOut | output | 2 | Per-channel period-end pulse |
| pwmOut | output | 1 | Pulse-width modulated output |

## Verification
The bench checks the PWM waveform from the first cycle after the start-both write. A design that started channel 1 one cycle late, or did not restart it at the boundary, would show a high time that is off by one or drifts. Duty counts equal to and greater than the period must give a flat low output; an off-by-one in the compare would instead give a glitch or a constant high. A load value is rewritten just after a rising edge: a design that applied it at once would stretch the high time of the current period. A wrong reload cycle would give periods of L+1 or L+3, so the down and up periods are timed cycle by cycle. The bench also checks the start-both strobe on the other channel's run bit, and confirms that the non-reloading channel clears its own run bit.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  localparam int CTRL_W = 12;

  localparam int B_CAPMODE = 0;
  localparam int B_DOWN    = 1;
  localparam int B_GEN     = 2;
  localparam int B_CAPEN   = 3;
  localparam int B_AUTO    = 4;
  localparam int B_LOAD    = 5;
  localparam int B_IRQEN   = 6;
  localparam int B_RUN     = 7;
  localparam int B_FLAG    = 8;
  localparam int B_PWM     = 9;
  localparam int B_ALL     = 10;
  localparam int B_CHAIN   = 11;

  // bits stored straight from a write; flag and start-both are handled apart
  localparam logic [CTRL_W-1:0] PLAIN_MASK = 12'hAFF;

  // control -> datapath
  typedef struct packed {
    logic [1:0] run;
    logic [1:0] down;
    logic [1:0] hold;
    logic [1:0] autoRld;
    logic [1:0] genOn;
    logic       pwmOn;
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic [1:0] wrapEv;
    logic [1:0] stopEv;
  } dpStat_t;

endpackage

// File: rtl/dtp_regs.sv
module dtp_regs
  import dtp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [4:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  dpStat_t              stat,
  input  logic [WIDTH-1:0]     count0,
  input  logic [WIDTH-1:0]     count1,
  output dpCtrl_t              ctl,
  output logic [WIDTH-1:0]     load0,
  output logic [WIDTH-1:0]     load1,
  output logic [CTRL_W-1:0]    ctrl0Q,
  output logic [CTRL_W-1:0]    ctrl1Q
);

  localparam int PADC = 32 - CTRL_W;

  logic       aligned;
  logic [2:0] sel;
  logic       enAllWr;
  logic [1:0] wrCtrl;
  logic [1:0][CTRL_W-1:0] ctrlV;
  logic [1:0][WIDTH-1:0]  loadV;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign sel     = regAddr[4:2];
  assign enAllWr = |wrCtrl & regWdata[B_ALL];

  for (genvar i = 0; i < 2; i++) begin : g_chan
    localparam logic [2:0] SEL_CTRL = 3'(4 * i);
    localparam logic [2:0] SEL_LOAD = 3'(4 * i + 1);

    logic             wrLoad;
    logic [CTRL_W-1:0] ctrlR;
    logic [CTRL_W-1:0] wrVal;
    logic [WIDTH-1:0]  loadR;

    assign wrCtrl[i] = regWe & aligned & (sel == SEL_CTRL);
    assign wrLoad    = regWe & aligned & (sel == SEL_LOAD);

    always_comb begin
      wrVal         = regWdata[CTRL_W-1:0] & PLAIN_MASK;
      wrVal[B_FLAG] = (ctrlR[B_FLAG] & ~regWdata[B_FLAG]) | stat.wrapEv[i];
      if (enAllWr) wrVal[B_RUN] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlR <= '0;
      end else if (wrCtrl[i]) begin
        ctrlR <= wrVal;
      end else begin
        if (stat.wrapEv[i]) ctrlR[B_FLAG] <= 1'b1;
        if (enAllWr)             ctrlR[B_RUN] <= 1'b1;
        else if (stat.stopEv[i]) ctrlR[B_RUN] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)       loadR <= '0;
      else if (wrLoad) loadR <= regWdata[WIDTH-1:0];
    end

    assign ctrlV[i] = ctrlR;
    assign loadV[i] = loadR;

    assign ctl.run[i]     = ctrlR[B_RUN];
    assign ctl.down[i]    = ctrlR[B_DOWN];
    assign ctl.hold[i]    = ctrlR[B_LOAD];
    assign ctl.autoRld[i] = ctrlR[B_AUTO];
    assign ctl.genOn[i]   = ctrlR[B_GEN] & ~ctrlR[B_CAPMODE];
  end

  // both channels must be in the pulse-width configuration
  function automatic logic pwmReady(input logic [CTRL_W-1:0] c);
    return ~c[B_CAPMODE] & c[B_PWM] & c[B_GEN] & c[B_RUN] &
           c[B_AUTO] & ~c[B_LOAD] & ~c[B_CHAIN];
  endfunction

  assign ctl.pwmOn = pwmReady(ctrlV[0]) & pwmReady(ctrlV[1]);

  assign ctrl0Q = ctrlV[0];
  assign ctrl1Q = ctrlV[1];
  assign load0  = loadV[0];
  assign load1  = loadV[1];

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (sel)
        3'd0:    regRdata = {{PADC{1'b0}}, ctrlV[0]};
        3'd1:    regRdata = 32'(loadV[0]);
        3'd2:    regRdata = 32'(count0);
        3'd4:    regRdata = {{PADC{1'b0}}, ctrlV[1]};
        3'd5:    regRdata = 32'(loadV[1]);
        3'd6:    regRdata = 32'(count1);
        default: regRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dtp_counters.sv
module dtp_counters
  import dtp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [WIDTH-1:0] load0,
  input  logic [WIDTH-1:0] load1,
  output logic [WIDTH-1:0] count0,
  output logic [WIDTH-1:0] count1,
  output dpStat_t          stat,
  output logic [1:0]       genOut,
  output logic             pwmOut
);

  localparam int              CW      = WIDTH + 2;
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [1:0][WIDTH-1:0] loadV;
  logic [1:0][WIDTH-1:0] countV;
  logic [1:0]            pendV;

  assign loadV[0] = load0;
  assign loadV[1] = load1;

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    logic             isTerm;
    logic             restartNow;
    logic [WIDTH-1:0] cntR;
    logic             pendR;

    assign isTerm = ctl.down[i] ? (cntR == '0) : (cntR == CNT_MAX);

    if (i == 1) begin : g_follow
      // channel 1 is realigned to every period boundary of channel 0
      assign restartNow = ctl.pwmOn & pendV[0];
    end else begin : g_lead
      assign restartNow = 1'b0;
    end

    assign stat.wrapEv[i] = ~ctl.hold[i] & ~restartNow & ~pendR &
                            ctl.run[i] & isTerm;
    assign stat.stopEv[i] = ~ctl.hold[i] & ~restartNow & pendR &
                            ~ctl.autoRld[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntR  <= '0;
        pendR <= 1'b0;
      end else if (ctl.hold[i]) begin
        cntR  <= loadV[i];
        pendR <= 1'b0;
      end else if (restartNow || (pendR && ctl.autoRld[i])) begin
        cntR  <= loadV[i];
        pendR <= 1'b0;
      end else if (pendR) begin
        pendR <= 1'b0;
      end else if (ctl.run[i]) begin
        cntR  <= ctl.down[i] ? cntR - 1'b1 : cntR + 1'b1;
        pendR <= isTerm;
      end
    end

    assign countV[i] = cntR;
    assign pendV[i]  = pendR;
    assign genOut[i] = pendR & ctl.genOn[i];
  end

  assign count0 = countV[0];
  assign count1 = countV[1];

  function automatic logic [CW-1:0] cycOf(input logic [WIDTH-1:0] l,
                                          input logic dn);
    return dn ? CW'(l) + CW'(2) : CW'(CNT_MAX) - CW'(l) + CW'(2);
  endfunction

  logic dutyNow, dutyQ, lowQ;

  assign dutyNow = cycOf(load1, ctl.down[1]) < cycOf(load0, ctl.down[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyQ <= 1'b0;
      lowQ  <= 1'b0;
    end else begin
      if (!ctl.pwmOn || pendV[0]) dutyQ <= dutyNow;
      if (!ctl.pwmOn)      lowQ <= 1'b0;
      else if (pendV[0])   lowQ <= 1'b0;
      else if (pendV[1])   lowQ <= 1'b1;
    end
  end

  assign pwmOut = ctl.pwmOn & dutyQ & ~lowQ;

endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
  import dtp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [4:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic [1:0]  genOut,
  output logic        pwmOut
);

  dpCtrl_t           ctl;
  dpStat_t           stat;
  logic [WIDTH-1:0]  count0, count1, load0, load1;
  logic [CTRL_W-1:0] ctrl0Q, ctrl1Q;
  logic              pwmActive;

  assign pwmActive = ctl.pwmOn;

  dtp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stat(stat),
    .count0(count0), .count1(count1), .ctl(ctl),
    .load0(load0), .load1(load1), .ctrl0Q(ctrl0Q), .ctrl1Q(ctrl1Q)
  );

  dtp_counters #(.WIDTH(WIDTH)) u_counters (
    .clk(clk), .rstN(rstN), .ctl(ctl), .load0(load0), .load1(load1),
    .count0(count0), .count1(count1), .stat(stat),
    .genOut(genOut), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/dtp_checker.sv
module dtp_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [4:0]       regAddr,
  input logic             allBit,
  input logic [1:0]       genOut,
  input logic             pwmOut,
  input logic             pwmActive,
  input logic             hold0,
  input logic             run0,
  input logic             run1,
  input logic [WIDTH-1:0] count0,
  input logic [WIDTH-1:0] load0
);

  logic ctrlWrite;
  assign ctrlWrite = regWe && (regAddr == 5'h00 || regAddr == 5'h10);

  // R3: a held counter shows the load value one edge later
  p_hold_copies_r3: assert property (@(posedge clk) disable iff (!rstN)
    hold0 |=> (count0 == $past(load0)));

  // R4: period pulses are one cycle wide
  p_gen_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    genOut[0] |=> !genOut[0]);

  p_gen1_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    genOut[1] |=> !genOut[1]);

  // R7: start-both strobe sets both run bits
  p_start_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && allBit) |=> (run0 && run1));

  // R11: low while inactive
  p_low_inactive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !pwmActive |-> !pwmOut);

  // R9: a rise while running happens only at a channel 0 period end
  p_rise_at_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pwmOut) && $past(pwmActive)) |-> $past(genOut[0]));

endmodule

bind dual_timer_pwm dtp_checker #(.WIDTH(WIDTH)) u_dtpChecker (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .allBit(regWdata[10]), .genOut(genOut), .pwmOut(pwmOut),
  .pwmActive(pwmActive), .hold0(ctrl0Q[5]), .run0(ctrl0Q[7]),
  .run1(ctrl1Q[7]), .count0(count0), .load0(load0)
);

// File: tb/test_dual_timer_pwm.sv
module test_dual_timer_pwm;

  localparam logic [31:0] C_DOWN = 32'h002;
  localparam logic [31:0] C_GEN  = 32'h004;
  localparam logic [31:0] C_AUTO = 32'h010;
  localparam logic [31:0] C_LOAD = 32'h020;
  localparam logic [31:0] C_RUN  = 32'h080;
  localparam logic [31:0] C_FLAG = 32'h100;
  localparam logic [31:0] C_PWM  = 32'h200;
  localparam logic [31:0] C_ALL  = 32'h400;
  localparam logic [31:0] C_CHN  = 32'h800;
  localparam logic [31:0] PWM_SET = C_GEN | C_AUTO | C_RUN | C_PWM;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  genOut;
  logic        pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_timer_pwm i_dual_timer_pwm (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .genOut(genOut),
    .pwmOut(pwmOut)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic stopAll();
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h0);
  endtask

  // returns at the negedge of the first cycle after the start edge
  task automatic pwmStart(input logic [31:0] l0, input logic [31:0] l1,
                          input logic [31:0] dn, input logic [31:0] extra0);
    wr(5'h04, l0);
    wr(5'h14, l1);
    wr(5'h00, C_LOAD | dn);
    wr(5'h10, C_LOAD | dn);
    wr(5'h00, (PWM_SET & ~C_RUN) | dn | extra0);
    wr(5'h10, PWM_SET | C_ALL | dn);
  endtask

  task automatic pwmPattern(input string req, input int per, input int hi,
                            input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, {31'b0, pwmOut}, {31'b0, (k % per) < hi});
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 reset pwm", {31'b0, pwmOut}, 32'h0);
    chk("R1 reset gen", {30'b0, genOut}, 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    wr(5'h00, MAXV);
    rd(5'h00, v);  chk("R2 ctrl0 mask", v, 32'h0000_0AFF);
    rd(5'h10, v);  chk("R7 other run bit set", v, C_RUN);
    stopAll();
    wr(5'h04, MAXV);
    rd(5'h04, v);  chk("R1 load0 readback", v, MAXV);
    wr(5'h04, 32'h55);
    wr(5'h00, C_LOAD);
    rd(5'h08, v);  chk("R3 load copies", v, 32'h55);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h1234);
    rd(5'h08, v);  chk("R1 count read-only", v, 32'h55);
    wr(5'h0C, 32'hFFFF);
    rd(5'h0C, v);  chk("R1 unmapped", v, 32'h0);
    rd(5'h09, v);  chk("R1 misaligned", v, 32'h0);
  endtask

  task automatic measureGen(input string req, input int expPer);
    int n = 0;
    int guard = 0;
    while (genOut[0] !== 1'b1 && guard < 200) begin
      @(negedge clk); guard++;
    end
    do begin
      @(negedge clk); n++;
    end while (genOut[0] !== 1'b1 && n < 200);
    chk(req, n, expPer);
  endtask

  task automatic testDownPeriod();
    wr(5'h04, 32'd10);
    wr(5'h00, C_LOAD | C_DOWN);
    wr(5'h00, C_DOWN | C_AUTO | C_RUN | C_GEN);
    measureGen("R4 down period", 12);
    measureGen("R4 down period again", 12);
    stopAll();
  endtask

  task automatic testUpPeriod();
    wr(5'h04, MAXV - 32'd5);
    wr(5'h00, C_LOAD);
    wr(5'h00, C_AUTO | C_RUN | C_GEN);
    measureGen("R5 up period", 7);
    stopAll();
  endtask

  task automatic testOneShot();
    logic [31:0] v;
    wr(5'h04, 32'd3);
    wr(5'h00, C_LOAD | C_DOWN);
    wr(5'h00, C_DOWN | C_RUN);
    repeat (10) @(negedge clk);
    rd(5'h00, v);  chk("R6 run cleared and flag set", v, C_DOWN | C_FLAG);
    rd(5'h08, v);  chk("R6 counter stopped", v, MAXV);
    wr(5'h00, C_FLAG);
    rd(5'h00, v);  chk("R6 flag cleared", v, 32'h0);
  endtask

  task automatic testEnableAll();
    logic [31:0] v, c0, c1;
    wr(5'h04, 32'd100);
    wr(5'h14, 32'd100);
    wr(5'h00, C_LOAD | C_DOWN);
    wr(5'h10, C_LOAD | C_DOWN);
    wr(5'h00, C_DOWN);
    wr(5'h10, C_DOWN | C_ALL);
    rd(5'h00, v);  chk("R7 run set on ch0", v, C_DOWN | C_RUN);
    rd(5'h10, v);  chk("R7 strobe reads zero", v, C_DOWN | C_RUN);
    rd(5'h08, c0);
    rd(5'h18, c1);
    chk("R7 same start cycle", c1, c0 - 32'd1);
    stopAll();
  endtask

  task automatic testPwmDown();
    pwmStart(32'd8, 32'd3, C_DOWN, 32'h0);
    pwmPattern("R9 down pwm 5/10", 10, 5, 40);
    stopAll();
    repeat (3) @(negedge clk);
    chk("R11 low after disable", {31'b0, pwmOut}, 32'h0);
  endtask

  task automatic testPwmUp();
    pwmStart(MAXV - 32'd8, MAXV - 32'd2, 32'h0, 32'h0);
    pwmPattern("R9 up pwm 4/10", 10, 4, 30);
    stopAll();
  endtask

  task automatic testFullDuty();
    pwmStart(32'd8, 32'd8, C_DOWN, 32'h0);
    pwmPattern("R10 equal duty low", 10, 0, 25);
    stopAll();
    pwmStart(32'd6, 32'd9, C_DOWN, 32'h0);
    pwmPattern("R10 larger duty low", 8, 0, 25);
    stopAll();
  endtask

  task automatic testInactive();
    pwmStart(32'd8, 32'd3, C_DOWN, C_CHN);
    pwmPattern("R8 chaining blocks pwm", 10, 0, 25);
    stopAll();
  endtask

  task automatic testLateLoad();
    int guard = 0;
    pwmStart(32'd8, 32'd3, C_DOWN, 32'h0);
    repeat (10) @(negedge clk);
    while (pwmOut !== 1'b1 && guard < 50) begin
      @(negedge clk); guard++;
    end
    // now in the first high cycle (k=0) of a period
    wr(5'h14, 32'd5);
    // now at k=2
    for (int k = 2; k < 30; k++) begin
      logic e;
      if (k < 10) e = (k < 5);
      else        e = ((k - 10) % 10) < 7;
      chk("R12 new high time from next period", {31'b0, pwmOut}, {31'b0, e});
      @(negedge clk);
    end
    stopAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testDownPeriod();
    testUpPeriod();
    testOneShot();
    testEnableAll();
    testPwmDown();
    testPwmUp();
    testFullDuty();
    testInactive();
    testLateLoad();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule